// File: doc/BRIEF.md
# Processor Security Rule Monitor

This block watches a 32-bit RISC processor pipeline from the side and tests a fixed set of architectural security rules on every clock cycle. It looks at the fetched instruction word and its program counter, at exception starts and their type codes, at the privilege level, at data-TLB permission outcomes and at the output register of a UART. It drives nothing back into the processor. Its only outputs are flags that report what it saw.

Each rule has its own fail flag. A flag sets one clock after the cycle in which its rule is broken. It then stays set until a synchronous clear is given, so a short violation is never lost. A single alarm output is raised whenever any flag is set. The base of the exception vector table is a parameter. The width of the exception type code and the width of the UART register are also parameters.

Top module: `sec_rule_monitor`

## Requirements
- R1: When `dtlb_done_i` is high with `dtlb_we_i` low (a read), `tlb_fault_i` must be high if either of two cases holds: user mode (`supv_i` low) with user-read permission `perm_i[0]` clear, or supervisor mode with supervisor-read permission `perm_i[2]` clear. Otherwise the cycle is a violation of rule 0.
- R2: When `dtlb_done_i` is high with `dtlb_we_i` high (a write), `tlb_fault_i` must be high if either of two cases holds: user mode with user-write permission `perm_i[1]` clear, or supervisor mode with supervisor-write permission `perm_i[3]` clear. Otherwise the cycle is a violation of rule 1.
- R3: In a cycle with `exc_start_i` high, an `exc_type_i` of 0 or of 16 and above is a violation of rule 2. The values 1 to 15, and any value while `exc_start_i` is low, are accepted.
- R4: While `fetch_valid_i` is high, a major opcode `fetch_insn_i[31:26]` in the range 11..16 or 22..27 (both ends included) is a violation of rule 3. A fetch word marked not valid is exempt.
- R5: If `uart_we_i` is low in cycle t, then `uart_data_i` in cycle t+2 must equal its value in cycle t+1. A difference is a violation of rule 4.
- R6: While `fetch_valid_i` is high, a `fetch_pc_i` below `VEC_BASE` is a violation of rule 5. This does not apply while `cpu_rst_i` is high or while `supv_i` is high.
- R7: A violation in cycle t sets `rule_fail_o[k]` for its rule k after the clock edge that ends cycle t. While no violation occurs, every flag stays 0.
- R8: A set flag stays set until `clr_i` is sampled high, and the clear leaves it at 0. A violation in the same cycle as the clear still sets its flag.
- R9: `alarm_o` is high exactly when at least one bit of `rule_fail_o` is high, and it changes in the same cycle as the flags.
- R10: A synchronous high `rst` clears all flags and `alarm_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| clr_i | input | 1 | Synchronous clear of the sticky flags |
| cpu_rst_i | input | 1 | Processor reset line, observed only |
| fetch_valid_i | input | 1 | Fetch word and PC are known in this cycle |
| fetch_insn_i | input | 32 | Fetched instruction word |
| fetch_pc_i | input | XLEN | Program counter of the fetch |
| exc_start_i | input | 1 | An exception begins this cycle |
| exc_type_i | input | EXC_W | Type code of the starting exception |
| supv_i | input | 1 | Processor is in supervisor mode |
| dtlb_done_i | input | 1 | Data-TLB lookup completes this cycle |
| dtlb_we_i | input | 1 | The access being translated is a write |
| perm_i | input | 4 | Page permissions: [0] user read, [1] user write, [2] supervisor read, [3] supervisor write |
| tlb_fault_i | input | 1 | Processor signals a protection fault |
| uart_we_i | input | 1 | Write enable of the UART output register |
| uart_data_i | input | UART_W | UART output register value |
| rule_fail_o | output | 6 | Sticky per-rule fail flags; bit k is rule k of R1..R6 |
| alarm_o | output | 1 | OR of all sticky flags |

## Verification
The permission rules are driven with denied and granted permissions in both privilege modes, with the fault present and absent. This separates a mode-select error from a wrong permission bit or a missing fault qualification. The opcode and exception rules are driven with the values on each side of every range edge, such as 10/11, 16/17, 21/22, 27/28, 0/1 and 15/16, and with the qualifying strobe low. This shows off-by-one errors in the range comparisons. The UART rule gets one sequence where the value changes in the cycle right after the low write enable, which is allowed, and one where it changes in the cycle after that, which is not. The sticky logic is tested by idling after a violation, by clearing, and by clearing in the same cycle as a new violation.

// File: rtl/sec_mon_pkg.sv
package sec_mon_pkg;
  localparam int NUM_RULES = 6;

  // rule positions in the flag vector
  localparam int R_RD_PERM  = 0;
  localparam int R_WR_PERM  = 1;
  localparam int R_EXC_TYPE = 2;
  localparam int R_OPCODE   = 3;
  localparam int R_UART     = 4;
  localparam int R_LOW_PC   = 5;

  // permission vector bit positions
  localparam int PB_UR = 0;
  localparam int PB_UW = 1;
  localparam int PB_SR = 2;
  localparam int PB_SW = 3;

  localparam int INSN_W = 32;
  localparam int OP_MSB = 31;
  localparam int OP_LSB = 26;
  localparam int OP_W   = OP_MSB - OP_LSB + 1;

  localparam logic [OP_W-1:0] BAD_A_LO = 6'd11;
  localparam logic [OP_W-1:0] BAD_A_HI = 6'd16;
  localparam logic [OP_W-1:0] BAD_B_LO = 6'd22;
  localparam logic [OP_W-1:0] BAD_B_HI = 6'd27;

  typedef logic [NUM_RULES-1:0] rule_vec_t;
endpackage

// File: rtl/smon_tlb_perm.sv
module smon_tlb_perm
  import sec_mon_pkg::*;
(
  input  logic       done_i,
  input  logic       we_i,
  input  logic       supv_i,
  input  logic [3:0] perm_i,
  input  logic       fault_i,
  output logic       rd_viol_o,
  output logic       wr_viol_o
);
  logic rd_denied;
  logic wr_denied;

  always_comb begin
    rd_denied = supv_i ? ~perm_i[PB_SR] : ~perm_i[PB_UR];
    wr_denied = supv_i ? ~perm_i[PB_SW] : ~perm_i[PB_UW];
    rd_viol_o = done_i & ~we_i & rd_denied & ~fault_i;
    wr_viol_o = done_i &  we_i & wr_denied & ~fault_i;
  end
endmodule

// File: rtl/smon_fetch_rules.sv
module smon_fetch_rules
  import sec_mon_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              EXC_W    = 5,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_2000
) (
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              supv_i,
  input  logic              cpu_rst_i,
  input  logic              exc_start_i,
  input  logic [EXC_W-1:0]  exc_type_i,
  output logic              op_viol_o,
  output logic              pc_viol_o,
  output logic              exc_viol_o
);
  localparam logic [EXC_W-1:0] EXC_LAST = EXC_W'(15);

  logic [OP_W-1:0] major;
  logic            in_a;
  logic            in_b;

  always_comb begin
    major      = insn_i[OP_MSB:OP_LSB];
    in_a       = (major >= BAD_A_LO) && (major <= BAD_A_HI);
    in_b       = (major >= BAD_B_LO) && (major <= BAD_B_HI);
    op_viol_o  = valid_i && (in_a || in_b);
    pc_viol_o  = valid_i && (pc_i < VEC_BASE) && !cpu_rst_i && !supv_i;
    exc_viol_o = exc_start_i && ((exc_type_i == '0) || (exc_type_i > EXC_LAST));
  end
endmodule

// File: rtl/smon_uart_stable.sv
module smon_uart_stable #(
  parameter int UART_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [UART_W-1:0] data_i,
  output logic              viol_o
);
  logic              we_d1;
  logic              we_d2;
  logic [UART_W-1:0] data_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_d1   <= 1'b1;
      we_d2   <= 1'b1;
      data_d1 <= '0;
    end else begin
      we_d1   <= we_i;
      we_d2   <= we_d1;
      data_d1 <= data_i;
    end
  end

  assign viol_o = !we_d2 && (data_i != data_d1);
endmodule

// File: rtl/smon_sticky_bank.sv
module smon_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] viol_i,
  output logic [N-1:0] flags_o,
  output logic         alarm_o
);
  logic [N-1:0] flags_nx;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign flags_nx[g] = viol_i[g] | (flags_o[g] & ~clr_i);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
      viol_i[g] |=> flags_o[g]);
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (flags_o[g] && !clr_i) |=> flags_o[g]);
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !viol_i[g]) |=> !flags_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      alarm_o <= 1'b0;
    end else begin
      flags_o <= flags_nx;
      alarm_o <= |flags_nx;
    end
  end

  p_alarm_or_r9: assert property (@(posedge clk) disable iff (rst)
    alarm_o == (|flags_o));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (flags_o == '0 && !alarm_o));
endmodule

// File: rtl/sec_rule_monitor.sv
module sec_rule_monitor
  import sec_mon_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              EXC_W    = 5,
  parameter int              UART_W   = 8,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 cpu_rst_i,
  input  logic                 fetch_valid_i,
  input  logic [INSN_W-1:0]    fetch_insn_i,
  input  logic [XLEN-1:0]      fetch_pc_i,
  input  logic                 exc_start_i,
  input  logic [EXC_W-1:0]     exc_type_i,
  input  logic                 supv_i,
  input  logic                 dtlb_done_i,
  input  logic                 dtlb_we_i,
  input  logic [3:0]           perm_i,
  input  logic                 tlb_fault_i,
  input  logic                 uart_we_i,
  input  logic [UART_W-1:0]    uart_data_i,
  output logic [NUM_RULES-1:0] rule_fail_o,
  output logic                 alarm_o
);
  rule_vec_t viol;
  logic rd_v, wr_v, op_v, pc_v, exc_v, uart_v;

  smon_tlb_perm i_perm (
    .done_i    (dtlb_done_i),
    .we_i      (dtlb_we_i),
    .supv_i    (supv_i),
    .perm_i    (perm_i),
    .fault_i   (tlb_fault_i),
    .rd_viol_o (rd_v),
    .wr_viol_o (wr_v)
  );

  smon_fetch_rules #(
    .XLEN     (XLEN),
    .EXC_W    (EXC_W),
    .VEC_BASE (VEC_BASE)
  ) i_fetch (
    .valid_i     (fetch_valid_i),
    .insn_i      (fetch_insn_i),
    .pc_i        (fetch_pc_i),
    .supv_i      (supv_i),
    .cpu_rst_i   (cpu_rst_i),
    .exc_start_i (exc_start_i),
    .exc_type_i  (exc_type_i),
    .op_viol_o   (op_v),
    .pc_viol_o   (pc_v),
    .exc_viol_o  (exc_v)
  );

  smon_uart_stable #(.UART_W(UART_W)) i_uart (
    .clk    (clk),
    .rst    (rst),
    .we_i   (uart_we_i),
    .data_i (uart_data_i),
    .viol_o (uart_v)
  );

  always_comb begin
    viol             = '0;
    viol[R_RD_PERM]  = rd_v;
    viol[R_WR_PERM]  = wr_v;
    viol[R_EXC_TYPE] = exc_v;
    viol[R_OPCODE]   = op_v;
    viol[R_UART]     = uart_v;
    viol[R_LOW_PC]   = pc_v;
  end

  smon_sticky_bank #(.N(NUM_RULES)) i_sticky (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .viol_i  (viol),
    .flags_o (rule_fail_o),
    .alarm_o (alarm_o)
  );

  // port-level checks across the flag registers
  p_user_read_r1: assert property (@(posedge clk) disable iff (rst)
    (dtlb_done_i && !dtlb_we_i && !supv_i && !perm_i[PB_UR] && !tlb_fault_i)
      |=> rule_fail_o[R_RD_PERM]);
  p_supv_write_r2: assert property (@(posedge clk) disable iff (rst)
    (dtlb_done_i && dtlb_we_i && supv_i && !perm_i[PB_SW] && !tlb_fault_i)
      |=> rule_fail_o[R_WR_PERM]);
  p_exc_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (exc_start_i && exc_type_i == '0) |=> rule_fail_o[R_EXC_TYPE]);
  p_opcode_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && fetch_insn_i[OP_MSB:OP_LSB] == BAD_B_HI)
      |=> rule_fail_o[R_OPCODE]);
  p_uart_flag_r5: assert property (@(posedge clk) disable iff (rst)
    uart_v |=> rule_fail_o[R_UART]);
  p_low_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && fetch_pc_i < VEC_BASE && !supv_i && !cpu_rst_i)
      |=> rule_fail_o[R_LOW_PC]);
endmodule

// File: tb/test_sec_rule_monitor.sv
module test_sec_rule_monitor;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr, cpu_rst, fetch_valid, exc_start, supv;
  logic        dtlb_done, dtlb_we, fault, uart_we;
  logic [31:0] insn, pc;
  logic [4:0]  exc_type;
  logic [3:0]  perm;
  logic [7:0]  uart_data;
  logic [5:0]  flags;
  logic        alarm;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_rule_monitor i_sec_rule_monitor (
    .clk(clk), .rst(rst), .clr_i(clr), .cpu_rst_i(cpu_rst),
    .fetch_valid_i(fetch_valid), .fetch_insn_i(insn), .fetch_pc_i(pc),
    .exc_start_i(exc_start), .exc_type_i(exc_type), .supv_i(supv),
    .dtlb_done_i(dtlb_done), .dtlb_we_i(dtlb_we), .perm_i(perm),
    .tlb_fault_i(fault), .uart_we_i(uart_we), .uart_data_i(uart_data),
    .rule_fail_o(flags), .alarm_o(alarm)
  );

  function automatic logic [31:0] op_word(input logic [5:0] op);
    return {op, 26'h0};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    clr = 0; cpu_rst = 0; fetch_valid = 1; insn = op_word(6'd0);
    pc = BASE + 32'h100; exc_start = 0; exc_type = 5'd1; supv = 0;
    dtlb_done = 0; dtlb_we = 0; perm = 4'hF; fault = 0; uart_we = 1;
  endtask

  task automatic check(input logic [5:0] exp, input string tag);
    logic exp_alarm;
    exp_alarm = |exp;
    checks++;
    if (flags !== exp || alarm !== exp_alarm) begin
      fails++;
      $display("FAIL %s: flags=%b alarm=%b expected flags=%b alarm=%b",
               tag, flags, alarm, exp, exp_alarm);
    end
  endtask

  task automatic clear_flags();
    idle();
    clr = 1;
    step();
    clr = 0;
  endtask

  // inputs already set for one cycle; capture, compare, then clean up
  task automatic expect_after(input logic [5:0] exp, input string tag);
    step();
    check(exp, tag);
    clear_flags();
  endtask

  task automatic t_reset();
    check(6'b0, "R10 reset state");
  endtask

  task automatic t_idle();
    idle();
    for (int i = 0; i < 4; i++) step();
    check(6'b0, "R7 idle traffic holds");
  endtask

  task automatic t_read_perm();
    idle(); dtlb_done = 1; perm = 4'b1110;
    expect_after(6'b000001, "R1 user read denied no fault");
    idle(); dtlb_done = 1; perm = 4'b1110; fault = 1;
    expect_after(6'b0, "R1 user read denied with fault");
    idle(); dtlb_done = 1; supv = 1; perm = 4'b1011;
    expect_after(6'b000001, "R1 supervisor read denied");
    idle(); dtlb_done = 1; supv = 1; perm = 4'b1110;
    expect_after(6'b0, "R1 supervisor read granted, user bit clear");
    idle(); dtlb_done = 0; perm = 4'b0000;
    expect_after(6'b0, "R1 no lookup done");
  endtask

  task automatic t_write_perm();
    idle(); dtlb_done = 1; dtlb_we = 1; perm = 4'b1101;
    expect_after(6'b000010, "R2 user write denied");
    idle(); dtlb_done = 1; dtlb_we = 1; supv = 1; perm = 4'b0111;
    expect_after(6'b000010, "R2 supervisor write denied");
    idle(); dtlb_done = 1; dtlb_we = 1; perm = 4'b1010;
    expect_after(6'b0, "R2 write with read bits clear");
  endtask

  task automatic t_exc_type();
    idle(); exc_start = 1; exc_type = 5'd0;
    expect_after(6'b000100, "R3 type 0");
    idle(); exc_start = 1; exc_type = 5'd16;
    expect_after(6'b000100, "R3 type 16");
    idle(); exc_start = 1; exc_type = 5'd1;
    expect_after(6'b0, "R3 type 1");
    idle(); exc_start = 1; exc_type = 5'd15;
    expect_after(6'b0, "R3 type 15");
    idle(); exc_start = 0; exc_type = 5'd0;
    expect_after(6'b0, "R3 no exception start");
  endtask

  task automatic t_opcode();
    logic [5:0] bad [4] = '{6'd11, 6'd16, 6'd22, 6'd27};
    logic [5:0] good[4] = '{6'd10, 6'd17, 6'd21, 6'd28};
    for (int i = 0; i < 4; i++) begin
      idle(); insn = op_word(bad[i]);
      expect_after(6'b001000, $sformatf("R4 opcode %0d", bad[i]));
      idle(); insn = op_word(good[i]);
      expect_after(6'b0, $sformatf("R4 opcode %0d", good[i]));
    end
    idle(); insn = op_word(6'd12); fetch_valid = 0;
    expect_after(6'b0, "R4 unknown fetch word exempt");
  endtask

  task automatic t_uart();
    idle(); uart_data = 8'h5A; uart_we = 0;
    step();
    uart_we = 1;
    step();
    uart_data = 8'h5B;
    step();
    check(6'b010000, "R5 change two cycles after low enable");
    clear_flags(); step(); step(); clear_flags();
    idle(); uart_data = 8'h5A; uart_we = 0;
    step();
    uart_we = 1; uart_data = 8'h77;
    step();
    step();
    check(6'b0, "R5 change one cycle after low enable allowed");
    clear_flags();
  endtask

  task automatic t_pc();
    idle(); pc = BASE - 32'd4;
    expect_after(6'b100000, "R6 low pc user mode");
    idle(); pc = BASE - 32'd4; supv = 1;
    expect_after(6'b0, "R6 low pc supervisor");
    idle(); pc = BASE - 32'd4; cpu_rst = 1;
    expect_after(6'b0, "R6 low pc during cpu reset");
    idle(); pc = BASE;
    expect_after(6'b0, "R6 pc at base");
  endtask

  task automatic t_sticky();
    idle(); dtlb_done = 1; perm = 4'b1110;
    step();
    idle();
    step(); step(); step();
    check(6'b000001, "R8 flag sticks while idle");
    clr = 1;
    step();
    clr = 0;
    check(6'b0, "R8 clear drops flag");
    idle(); clr = 1; exc_start = 1; exc_type = 5'd0;
    step();
    check(6'b000100, "R8 violation during clear still sets");
    clear_flags();
  endtask

  task automatic t_multi();
    idle(); insn = op_word(6'd23); pc = BASE - 32'd8;
    step();
    idle();
    check(6'b101000, "R9 two rules, alarm set");
    clear_flags();
    check(6'b0, "R9 alarm drops with flags");
  endtask

  task automatic t_reset_mid();
    idle(); exc_start = 1; exc_type = 5'd20;
    step();
    idle(); rst = 1;
    step();
    rst = 0;
    check(6'b0, "R10 reset clears flags");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle();
    uart_data = 8'h00;
    rst = 1;
    step(); step();
    rst = 0;
    t_reset();
    t_idle();
    t_read_perm();
    t_write_perm();
    t_exc_type();
    t_opcode();
    t_uart();
    t_pc();
    t_sticky();
    t_multi();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule